// File: doc/BRIEF.md
# IR Carrier Transmit Modulator

The block produces a modulated infrared drive signal. A power-of-two prescaler divides the system clock into an IR clock tick. A carrier generator built on that tick alternates between a high phase and a low phase, and the length of each phase is set by its own 8-bit count. An envelope timer cuts time into back-to-back periods whose length comes from a 16-bit modulator time value. At the start of each period the timer latches a one-bit data level. The output is the carrier where that level is 1 and is held low where it is 0.

Each time the envelope timer reloads, it raises a sticky flag. An interrupt request follows the flag when the enable bit is set. Software writes the registers through a simple write port: control, carrier counts, modulator time and flag clear. During each period it stages the data level and, if it wants, a new period length for the next period. Both are picked up only at the next reload, so the period in progress always runs to its end.

Top module: `ir_carrier_mod`

## Requirements
- R1: While running, the IR clock ticks once every 2^D system clocks, where D is control bits [2:0] at address 0 (D = 0 gives a tick every cycle, D = 7 gives a tick every 128 cycles).
- R2: Each carrier high phase lasts (H + 1) IR ticks, where H is bits [7:0] of the carrier register at address 1.
- R3: Each carrier low phase lasts (L + 1) IR ticks, where L is bits [15:8] of the carrier register at address 1.
- R4: Each envelope period lasts (M + 1) IR ticks, where M is the 16-bit modulator time at address 2. At every reload the data level in control bit 5 is latched for the coming period. The carrier restarts in its high phase at each reload, and `ir_out` is the carrier during a period with level 1 and 0 during a period with level 0.
- R5: Every envelope reload sets `flag`. The first reload happens on the first IR tick after run is set.
- R6: `flag` stays set until a write to address 3 with bit 0 equal to 0. A write with bit 0 equal to 1 leaves it unchanged, and a reload in the same cycle as a clear wins.
- R7: `irq` is 1 exactly when `flag` is 1 and the interrupt enable, control bit 4, is 1.
- R8: A modulator time written during a period takes effect only at the next reload. The period in progress keeps its old length.
- R9: While the run bit (control bit 3) is 0, `ir_out` is 0 and no reload occurs, so `flag` is not set.
- R10: Reset clears the control, carrier and modulator time registers and `flag`. With all counts at zero and run and level set, `ir_out` stays high and a reload happens on every tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 carrier, 2 modulator time, 3 flag |
| wr_data | input | 16 | Write data |
| ir_out | output | 1 | Modulated IR output |
| flag | output | 1 | Sticky reload flag |
| irq | output | 1 | Interrupt request, flag gated by enable |

## Verification
The carrier is measured with three patterns of divider and phase counts: symmetric-free counts at divide-by-1, minimum counts at divide-by-4, and a zero low count at divide-by-8. Each high and low run is compared in system cycles with (count + 1) · 2^D, which separates the high and low fields and catches a prescaler that is off by one power of two. The envelope period is timed from flag to flag at two dividers. A modulator time rewritten in mid-period shows whether the period in progress is cut short. Separate runs with data level 0, with run cleared and with the all-zero reset values, plus a sequence of flag writes and enable changes, tell gating, idling and sticky-flag faults apart from counting faults.

// File: rtl/irmod_pkg.sv
package irmod_pkg;
  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_CARR  = 2'd1,
    REG_MTIME = 2'd2,
    REG_FLAG  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/irmod_prescale.sv
module irmod_prescale #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_sel,
  output logic             tick
);
  localparam int PRE_W = (1 << DIV_W) - 1;

  // ones in the low div_sel bits: tick when they are all set
  function automatic logic [PRE_W-1:0] tick_mask(input logic [DIV_W-1:0] s);
    tick_mask = PRE_W'((1 << s) - 1);
  endfunction

  logic [PRE_W-1:0] pcnt;

  always_ff @(posedge clk) begin
    if (!rst_n)    pcnt <= '0;
    else if (!run) pcnt <= '0;
    else           pcnt <= pcnt + 1'b1;
  end

  assign tick = run && ((pcnt & tick_mask(div_sel)) == tick_mask(div_sel));

  // R1: two ticks in a row only at divide-by-1
  p_back_to_back_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && $past(tick) && $past(run) && $stable(div_sel)) |-> (div_sel == '0));
  // R9: no IR clock while idle
  p_idle_no_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick);
endmodule

// File: rtl/irmod_carrier.sv
module irmod_carrier #(
  parameter int CAR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             reload,
  input  logic [CAR_W-1:0] hi_cnt,
  input  logic [CAR_W-1:0] lo_cnt,
  output logic             phase_hi
);
  logic [CAR_W-1:0] ccnt;
  logic             phase_end;

  assign phase_end = tick && !reload && (ccnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_hi <= 1'b1;
      ccnt     <= '0;
    end else if (reload) begin
      phase_hi <= 1'b1;
      ccnt     <= hi_cnt;
    end else if (phase_end) begin
      phase_hi <= !phase_hi;
      ccnt     <= phase_hi ? lo_cnt : hi_cnt;
    end else if (tick) begin
      ccnt     <= ccnt - 1'b1;
    end
  end

  // R4: every envelope period begins in the high phase
  p_reload_starts_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> phase_hi);
  // R2: the phase never flips between IR ticks
  p_flip_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(phase_hi));
endmodule

// File: rtl/irmod_envelope.sv
module irmod_envelope #(
  parameter int MT_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            tick,
  input  logic [MT_W-1:0] mtime,
  input  logic            level_nxt,
  output logic            env,
  output logic            reload
);
  logic [MT_W-1:0] ecnt;

  assign reload = tick && (ecnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      ecnt <= '0;
      env  <= 1'b0;
    end else if (reload) begin
      ecnt <= mtime;
      env  <= level_nxt;
    end else if (tick) begin
      ecnt <= ecnt - 1'b1;
    end
  end

  // R9: envelope drops once run is cleared
  p_idle_env_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !env);
  // R4: level changes only at a reload while running
  p_env_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !reload) |=> $stable(env));
endmodule

// File: rtl/ir_carrier_mod.sv
module ir_carrier_mod
  import irmod_pkg::*;
#(
  parameter int DIV_W = 3,
  parameter int CAR_W = 8,
  parameter int MT_W  = 16,
  localparam int BUS_W = (2 * CAR_W > MT_W) ? 2 * CAR_W : MT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [BUS_W-1:0] wr_data,
  output logic             ir_out,
  output logic             flag,
  output logic             irq
);
  localparam int RUN_BIT = DIV_W;
  localparam int IE_BIT  = DIV_W + 1;
  localparam int LVL_BIT = DIV_W + 2;

  logic [DIV_W-1:0] div_sel;
  logic             run, irq_en, level_nxt;
  logic [CAR_W-1:0] hi_cnt, lo_cnt;
  logic [MT_W-1:0]  mtime;

  // internal events brought out for checking
  logic tick, reload, env, phase_hi, clear_hit;

  assign clear_hit = wr_en && (wr_addr == REG_FLAG) && !wr_data[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_sel   <= '0;
      run       <= 1'b0;
      irq_en    <= 1'b0;
      level_nxt <= 1'b0;
      hi_cnt    <= '0;
      lo_cnt    <= '0;
      mtime     <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        REG_CTRL: begin
          div_sel   <= wr_data[DIV_W-1:0];
          run       <= wr_data[RUN_BIT];
          irq_en    <= wr_data[IE_BIT];
          level_nxt <= wr_data[LVL_BIT];
        end
        REG_CARR: begin
          hi_cnt <= wr_data[CAR_W-1:0];
          lo_cnt <= wr_data[2*CAR_W-1:CAR_W];
        end
        REG_MTIME: mtime <= wr_data[MT_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         flag <= 1'b0;
    else if (reload)    flag <= 1'b1;
    else if (clear_hit) flag <= 1'b0;
  end

  irmod_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .div_sel(div_sel), .tick(tick));

  irmod_envelope #(.MT_W(MT_W)) u_env (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .mtime(mtime),
    .level_nxt(level_nxt), .env(env), .reload(reload));

  irmod_carrier #(.CAR_W(CAR_W)) u_car (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reload(reload),
    .hi_cnt(hi_cnt), .lo_cnt(lo_cnt), .phase_hi(phase_hi));

  assign ir_out = env && phase_hi;
  assign irq    = flag && irq_en;

  // R5: each reload leaves the flag set
  p_flag_on_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> flag);
  // R6: only a clear write drops the flag
  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clear_hit) |=> flag);
  // R9: output quiet one cycle after run is cleared
  p_idle_out_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && $past(!run)) |-> !ir_out);
endmodule

// File: tb/ir_carrier_mod_test.sv
module ir_carrier_mod_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        ir_out, flag, irq;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  always #4 clk = !clk;
  always @(posedge clk) cyc <= cyc + 1;

  ir_carrier_mod uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ir_out(ir_out), .flag(flag), .irq(irq));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ctl(input int dv, input bit rn, input bit ie, input bit lv);
    ctl = 16'(dv) | (16'(rn) << 3) | (16'(ie) << 4) | (16'(lv) << 5);
  endfunction

  // expected length in system cycles: count+1 ticks, each 2^dv cycles long
  function automatic int span(input int n, input int dv);
    int t;
    t = n + 1;
    for (int i = 0; i < dv; i++) t = t * 2;
    span = t;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_flag(output int ts);
    forever begin
      @(negedge clk);
      if (flag) break;
    end
    ts = cyc;
  endtask

  task automatic t_reset();
    chk(ir_out == 1'b0, "R10 ir_out after reset", ir_out, 0);
    chk(flag == 1'b0, "R10 flag after reset", flag, 0);
    chk(irq == 1'b0, "R10 irq after reset", irq, 0);
    wr(2'd0, ctl(0, 1, 0, 1));
    @(negedge clk);
    begin
      int highs = 0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (ir_out) highs++;
      end
      chk(highs == 10, "R10 zero counts keep output high", highs, 10);
    end
    chk(flag == 1'b1, "R10 zero modulator time reloads", flag, 1);
    wr(2'd0, 16'h0000);
    wr(2'd3, 16'h0000);
  endtask

  task automatic t_carrier(input int dv, input int hi, input int lo);
    int h1, l1, h2;
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'((lo << 8) | hi));
    wr(2'd2, 16'hFFFF);
    wr(2'd0, ctl(dv, 1, 0, 1));
    while (!ir_out) @(negedge clk);
    h1 = 0; while (ir_out)  begin h1++; @(negedge clk); end
    l1 = 0; while (!ir_out) begin l1++; @(negedge clk); end
    h2 = 0; while (ir_out)  begin h2++; @(negedge clk); end
    chk(h1 == span(hi, dv), "R2 first high width", h1, span(hi, dv));
    chk(l1 == span(lo, dv), "R3 low width", l1, span(lo, dv));
    chk(h2 == span(hi, dv), "R1 second high width", h2, span(hi, dv));
    wr(2'd0, 16'h0000);
    wr(2'd3, 16'h0000);
  endtask

  task automatic t_period(input int dv, input int mt, input int mt2);
    int ta, tb, tc, td;
    wr(2'd0, 16'h0000);
    wr(2'd3, 16'h0000);
    wr(2'd1, 16'h0101);
    wr(2'd2, 16'(mt));
    wr(2'd0, ctl(dv, 1, 0, 1));
    wait_flag(ta); wr(2'd3, 16'h0000);
    wait_flag(tb); wr(2'd3, 16'h0000);
    chk(tb - ta == span(mt, dv), "R4 envelope period", tb - ta, span(mt, dv));
    wr(2'd2, 16'(mt2));
    wait_flag(tc); wr(2'd3, 16'h0000);
    chk(tc - tb == span(mt, dv), "R8 current period not cut", tc - tb, span(mt, dv));
    wait_flag(td); wr(2'd3, 16'h0000);
    chk(td - tc == span(mt2, dv), "R8 new period length", td - tc, span(mt2, dv));
    wr(2'd0, 16'h0000);
    wr(2'd3, 16'h0000);
  endtask

  task automatic t_level();
    int ts, highs;
    wr(2'd0, 16'h0000);
    wr(2'd3, 16'h0000);
    wr(2'd1, 16'h0101);
    wr(2'd2, 16'd50);
    wr(2'd0, ctl(0, 1, 0, 0));
    wait_flag(ts); wr(2'd3, 16'h0000);
    highs = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (ir_out) highs++;
    end
    chk(highs == 0, "R4 level 0 holds output low", highs, 0);
    wr(2'd0, ctl(0, 1, 0, 1));
    wait_flag(ts);
    chk(ir_out == 1'b1, "R4 level 1 period starts high", ir_out, 1);
    wr(2'd3, 16'h0000);
  endtask

  task automatic t_idle();
    int highs;
    wr(2'd0, ctl(0, 0, 0, 1));
    @(negedge clk);
    wr(2'd3, 16'h0000);
    highs = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (ir_out) highs++;
    end
    chk(highs == 0, "R9 output low while stopped", highs, 0);
    chk(flag == 1'b0, "R9 no reload while stopped", flag, 0);
  endtask

  task automatic t_flag();
    int ts;
    wr(2'd2, 16'd5);
    wr(2'd0, ctl(0, 1, 0, 1));
    wait_flag(ts);
    chk(flag == 1'b1, "R5 flag set by reload", flag, 1);
    wr(2'd0, ctl(0, 0, 0, 1));
    chk(irq == 1'b0, "R7 irq masked when disabled", irq, 0);
    wr(2'd0, ctl(0, 0, 1, 1));
    chk(irq == 1'b1, "R7 irq follows flag when enabled", irq, 1);
    wr(2'd3, 16'h0001);
    chk(flag == 1'b1, "R6 writing 1 keeps flag", flag, 1);
    wr(2'd3, 16'h0000);
    chk(flag == 1'b0, "R6 writing 0 clears flag", flag, 0);
    chk(irq == 1'b0, "R7 irq drops with flag", irq, 0);
    wr(2'd0, 16'h0000);
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_carrier(0, 2, 4);
    t_carrier(2, 0, 1);
    t_carrier(3, 5, 0);
    t_period(1, 20, 9);
    t_period(3, 4, 2);
    t_level();
    t_idle();
    t_flag();
    report();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    report();
    $finish;
  end
endmodule